// File: doc/BRIEF.md
# Two-Level IO Address Translator

This block maps 32-bit device-side virtual addresses to physical addresses. It walks a two-level table in memory. A requester presents one virtual address while the block is idle. The block then fetches a directory word, and if that word is usable, it fetches a leaf word. It returns a single response: either a physical address with the leaf's 4-bit access control index, or one of two fault codes. Word reads leave through a plain request/response memory port. The block serves one requester at a time and keeps no cached entries.

The directory base address and the translation enable come from an external control register. When translation is off, requests pass straight through unchanged and no memory read is made. After a fault, the faulting virtual address stays visible on a dedicated output until the next request is taken.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o`, `mem_req_o` and `fault_va_o` are 0.
- R2: With translation enabled, an accepted request issues exactly one directory read, as a one-cycle `mem_req_o` pulse. Its address is `dir_base_i + 4*va[31:20]`.
- R3: A directory word is usable only when its bits 1:0 equal 2'b01. Any other value (00, 10, 11) ends the walk with `rsp_fault_o` = 1 and no leaf read. Directory bits 9:2 have no effect.
- R4: After a usable directory word `d`, exactly one leaf read follows, at address `{d[31:10],10'b0} + 4*va[19:12]`.
- R5: A leaf word with bit 1 clear ends the walk with `rsp_fault_o` = 2.
- R6: A leaf word with bit 1 set gives `rsp_fault_o` = 0, `rsp_pa_o` = `{leaf[31:12], va[11:0]}` and `rsp_aci_o` = `leaf[7:4]`. Leaf bits 11:8, 3:2 and 0 have no effect.
- R7: `rsp_valid_o` is a one-cycle pulse. Its timing is counted in cycles after the accepting edge, where L is the number of cycles the memory holds back each response beyond the first. A full walk responds in cycle 5+2L, a directory fault in cycle 3+L, and a bypass in cycle 1. `req_ready_o` returns to 1 in the following cycle.
- R8: A request is taken only while `req_ready_o` is 1. `req_valid_i` held high while busy causes no extra read and does not change the response.
- R9: With `xlat_en_i` low at acceptance, the request completes with no memory read, `rsp_pa_o` equal to the input address, `rsp_aci_o` = 0 and `rsp_fault_o` = 0.
- R10: `fault_va_o` shows the faulting virtual address from the faulting response onward, clears to 0 when the next request is taken, and stays 0 across successful responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xlat_en_i | input | 1 | Translation enable; low selects pass-through |
| dir_base_i | input | 32 | Physical address of the first-level directory |
| req_valid_i | input | 1 | Translation request strobe |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | High while idle; a request is taken on this cycle |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | 32 | Byte address of the word to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_pa_o | output | 32 | Translated physical address |
| rsp_aci_o | output | 4 | Access control index from the leaf word |
| rsp_fault_o | output | 2 | 0 none, 1 directory invalid, 2 leaf invalid |
| fault_va_o | output | 32 | Held faulting virtual address |

## Verification
The bench uses the package defaults: a 12/8/12 split, which gives a 4096-entry directory and 256-entry leaf tables. At this size every directory index can be walked, and all 256 leaf slots under one directory entry can be walked as well. The memory model builds each word from its address. As a result, the sweep meets all four directory valid-bit encodings, leaf words with and without the valid bit, and reserved bits set to one. The memory response delay varies from zero to two extra cycles, which exercises the latency arithmetic. Pass-through and busy-time request cases are then layered on top.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
  parameter int unsigned ADDR_W      = 32;
  parameter int unsigned L1_IDX_W    = 12;
  parameter int unsigned L2_IDX_W    = 8;
  parameter int unsigned PG_OFF_W    = 12;
  parameter int unsigned ENT_SHIFT   = 2;   // four-byte entries
  parameter int unsigned TBL_ALIGN_W = 10;  // leaf tables are 1 KiB aligned
  parameter int unsigned ACI_W       = 4;
  parameter int unsigned ACI_LSB     = 4;
  parameter int unsigned LEAF_OK_BIT = 1;
  parameter int unsigned DIR_TAG_W   = 2;
  parameter logic [DIR_TAG_W-1:0] DIR_TAG_OK = 2'b01;

  localparam int unsigned L1_IDX_LSB = PG_OFF_W + L2_IDX_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ACI_W-1:0]  aci_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_L1, ST_WAIT_L1, ST_READ_L2, ST_WAIT_L2, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_LEAF = 2'd2
  } flt_e;

  function automatic addr_t dir_entry_addr(input addr_t base, input addr_t va);
    addr_t idx;
    idx = addr_t'(va[ADDR_W-1:L1_IDX_LSB]);
    return base + (idx << ENT_SHIFT);
  endfunction

  function automatic addr_t leaf_tbl_base(input addr_t dte);
    return {dte[ADDR_W-1:TBL_ALIGN_W], TBL_ALIGN_W'(0)};
  endfunction

  function automatic addr_t leaf_entry_addr(input addr_t tbl, input addr_t va);
    addr_t idx;
    idx = addr_t'(va[L1_IDX_LSB-1:PG_OFF_W]);
    return tbl + (idx << ENT_SHIFT);
  endfunction

  function automatic logic dir_entry_ok(input addr_t dte);
    return dte[DIR_TAG_W-1:0] == DIR_TAG_OK;
  endfunction

  function automatic logic leaf_entry_ok(input addr_t pte);
    return pte[LEAF_OK_BIT];
  endfunction

  function automatic addr_t leaf_phys(input addr_t pte, input addr_t va);
    return {pte[ADDR_W-1:PG_OFF_W], va[PG_OFF_W-1:0]};
  endfunction

  function automatic aci_t leaf_aci(input addr_t pte);
    return pte[ACI_LSB +: ACI_W];
  endfunction
endpackage

// File: rtl/iova_walk_fsm.sv
module iova_walk_fsm
  import iova_walk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  logic     xlat_en_i,
  input  logic     mem_rvalid_i,
  input  logic     dir_ok_i,
  input  logic     leaf_ok_i,
  output walk_st_e state_o,
  output logic     ev_accept_o,
  output logic     ev_bypass_o,
  output logic     ev_dir_ok_o,
  output logic     ev_dir_flt_o,
  output logic     ev_leaf_ok_o,
  output logic     ev_leaf_flt_o
);
  walk_st_e st_q, st_d;

  always_comb begin
    ev_accept_o   = (st_q == ST_IDLE) && req_valid_i;
    ev_bypass_o   = ev_accept_o && !xlat_en_i;
    ev_dir_ok_o   = (st_q == ST_WAIT_L1) && mem_rvalid_i && dir_ok_i;
    ev_dir_flt_o  = (st_q == ST_WAIT_L1) && mem_rvalid_i && !dir_ok_i;
    ev_leaf_ok_o  = (st_q == ST_WAIT_L2) && mem_rvalid_i && leaf_ok_i;
    ev_leaf_flt_o = (st_q == ST_WAIT_L2) && mem_rvalid_i && !leaf_ok_i;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_accept_o) st_d = xlat_en_i ? ST_READ_L1 : ST_DONE;
      end
      ST_READ_L1: st_d = ST_WAIT_L1;
      ST_WAIT_L1: begin
        if (ev_dir_ok_o)       st_d = ST_READ_L2;
        else if (ev_dir_flt_o) st_d = ST_DONE;
      end
      ST_READ_L2: st_d = ST_WAIT_L2;
      ST_WAIT_L2: begin
        if (mem_rvalid_i) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/iova_walk_path.sv
module iova_walk_path
  import iova_walk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  walk_st_e state_i,
  input  logic     ev_accept_i,
  input  logic     ev_bypass_i,
  input  logic     ev_dir_ok_i,
  input  logic     ev_dir_flt_i,
  input  logic     ev_leaf_ok_i,
  input  logic     ev_leaf_flt_i,
  input  addr_t    dir_base_i,
  input  addr_t    req_va_i,
  input  addr_t    mem_rdata_i,
  output addr_t    mem_addr_o,
  output logic     dir_ok_o,
  output logic     leaf_ok_o,
  output addr_t    va_o,
  output addr_t    pa_o,
  output aci_t     aci_o,
  output flt_e     flt_o
);
  addr_t va_q, tbl_q, pa_q;
  aci_t  aci_q;
  flt_e  flt_q;

  assign dir_ok_o  = dir_entry_ok(mem_rdata_i);
  assign leaf_ok_o = leaf_entry_ok(mem_rdata_i);

  always_comb begin
    if (state_i == ST_READ_L2) mem_addr_o = leaf_entry_addr(tbl_q, va_q);
    else                       mem_addr_o = dir_entry_addr(dir_base_i, va_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q  <= '0;
      tbl_q <= '0;
    end else begin
      if (ev_accept_i) va_q  <= req_va_i;
      if (ev_dir_ok_i) tbl_q <= leaf_tbl_base(mem_rdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= '0;
      aci_q <= '0;
      flt_q <= FLT_NONE;
    end else if (ev_bypass_i) begin
      pa_q  <= req_va_i;
      aci_q <= '0;
      flt_q <= FLT_NONE;
    end else if (ev_dir_flt_i) begin
      pa_q  <= '0;
      aci_q <= '0;
      flt_q <= FLT_DIR;
    end else if (ev_leaf_flt_i) begin
      pa_q  <= '0;
      aci_q <= '0;
      flt_q <= FLT_LEAF;
    end else if (ev_leaf_ok_i) begin
      pa_q  <= leaf_phys(mem_rdata_i, va_q);
      aci_q <= leaf_aci(mem_rdata_i);
      flt_q <= FLT_NONE;
    end
  end

  assign va_o  = va_q;
  assign pa_o  = pa_q;
  assign aci_o = aci_q;
  assign flt_o = flt_q;
endmodule

// File: rtl/iova_fault_hold.sv
module iova_fault_hold
  import iova_walk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  capture_i,
  input  addr_t va_i,
  output addr_t fault_va_o
);
  addr_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (clear_i)   hold_q <= '0;
    else if (capture_i) hold_q <= va_i;
  end

  assign fault_va_o = hold_q;
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlat_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_va_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_pa_o,
  output logic [ACI_W-1:0]  rsp_aci_o,
  output logic [1:0]        rsp_fault_o,
  output logic [ADDR_W-1:0] fault_va_o
);
  walk_st_e state;
  logic ev_accept, ev_bypass, ev_dir_ok, ev_dir_flt, ev_leaf_ok, ev_leaf_flt;
  logic dir_ok, leaf_ok;
  addr_t va_cur;
  flt_e  flt;

  iova_walk_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .xlat_en_i     (xlat_en_i),
    .mem_rvalid_i  (mem_rvalid_i),
    .dir_ok_i      (dir_ok),
    .leaf_ok_i     (leaf_ok),
    .state_o       (state),
    .ev_accept_o   (ev_accept),
    .ev_bypass_o   (ev_bypass),
    .ev_dir_ok_o   (ev_dir_ok),
    .ev_dir_flt_o  (ev_dir_flt),
    .ev_leaf_ok_o  (ev_leaf_ok),
    .ev_leaf_flt_o (ev_leaf_flt)
  );

  iova_walk_path u_path (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .ev_accept_i   (ev_accept),
    .ev_bypass_i   (ev_bypass),
    .ev_dir_ok_i   (ev_dir_ok),
    .ev_dir_flt_i  (ev_dir_flt),
    .ev_leaf_ok_i  (ev_leaf_ok),
    .ev_leaf_flt_i (ev_leaf_flt),
    .dir_base_i    (dir_base_i),
    .req_va_i      (req_va_i),
    .mem_rdata_i   (mem_rdata_i),
    .mem_addr_o    (mem_addr_o),
    .dir_ok_o      (dir_ok),
    .leaf_ok_o     (leaf_ok),
    .va_o          (va_cur),
    .pa_o          (rsp_pa_o),
    .aci_o         (rsp_aci_o),
    .flt_o         (flt)
  );

  iova_fault_hold u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (ev_accept),
    .capture_i  (ev_dir_flt || ev_leaf_flt),
    .va_i       (va_cur),
    .fault_va_o (fault_va_o)
  );

  assign req_ready_o = (state == ST_IDLE);
  assign mem_req_o   = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign rsp_valid_o = (state == ST_DONE);
  assign rsp_fault_o = flt;
endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        xlat_en_i,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_fault_o,
  input logic [31:0] fault_va_o,
  input logic        ev_accept,
  input logic        ev_bypass,
  input logic        ev_dir_ok,
  input logic        ev_dir_flt,
  input logic        ev_leaf_flt
);
  a_r2_read_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r2_walk_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_accept && xlat_en_i) |=> mem_req_o);

  a_r3_dir_fault_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_dir_flt |=> (rsp_valid_o && rsp_fault_o == 2'd1 && !mem_req_o));

  a_r4_leaf_read_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_dir_ok |=> mem_req_o);

  a_r5_leaf_fault_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_leaf_flt |=> (rsp_valid_o && rsp_fault_o == 2'd2));

  a_r7_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  a_r9_bypass_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_bypass |=> (rsp_valid_o && !mem_req_o && rsp_fault_o == 2'd0));

  a_r10_fault_va_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_accept && !ev_dir_flt && !ev_leaf_flt) |=> $stable(fault_va_o));
endmodule

bind iova_walker iova_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xlat_en_i   (xlat_en_i),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .fault_va_o  (fault_va_o),
  .ev_accept   (ev_accept),
  .ev_bypass   (ev_bypass),
  .ev_dir_ok   (ev_dir_ok),
  .ev_dir_flt  (ev_dir_flt),
  .ev_leaf_flt (ev_leaf_flt)
);

// File: tb/iova_walker_bench.sv
`timescale 1ns/1ps
module iova_walker_bench;
  localparam logic [31:0] BASE = 32'h9000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready_o, mem_req_o, rsp_valid_o;
  logic [31:0] mem_addr_o, rsp_pa_o, fault_va_o;
  logic [3:0]  rsp_aci_o;
  logic [1:0]  rsp_fault_o;

  int total = 0;
  int bad = 0;
  int mem_lat = 0;
  int nreads = 0;
  int wait_left = 0;
  bit pend = 0;
  logic [31:0] paddr = '0;
  logic [31:0] addr_log [2];

  always #2 clk = ~clk;

  iova_walker u_iova_walker (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(xlat_en), .dir_base_i(BASE),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_ready_o(req_ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid_o), .rsp_pa_o(rsp_pa_o), .rsp_aci_o(rsp_aci_o),
    .rsp_fault_o(rsp_fault_o), .fault_va_o(fault_va_o)
  );

  // Memory image computed from the address.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] idx;
    logic [11:0] l1;
    logic [7:0]  l2;
    logic [19:0] frame;
    int s;
    logic v;
    if (a >= BASE && a < BASE + 32'h4000) begin
      idx = (a - BASE) >> 2;
      return {4'h4, idx[11:0], 6'h15, idx[7:0], idx[1:0]};
    end else if (a[31:28] == 4'h4) begin
      l1 = a[27:16];
      l2 = a[9:2];
      s = int'(l1) + int'(l2);
      v = (s % 3) != 0;
      frame = {l2, l1} ^ 20'h5A3C6;
      return {frame, 4'hF, 4'(s), 2'b11, v, 1'b1};
    end
    return 32'hDEAD_BEEF;
  endfunction

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (wait_left == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem_word(paddr);
        pend = 0;
      end else begin
        wait_left = wait_left - 1;
      end
    end
    if (mem_req_o) begin
      pend = 1;
      paddr = mem_addr_o;
      wait_left = mem_lat;
      if (nreads < 2) addr_log[nreads] = mem_addr_o;
      nreads = nreads + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] va, input logic en, input int lat,
                        input bit noise);
    logic [31:0] dte, pte, exp_pa, exp_l1a, exp_l2a, exp_fva;
    logic [3:0]  exp_aci;
    logic [1:0]  exp_flt;
    int exp_lat, exp_reads, cyc;
    string tag;
    exp_l1a = BASE + (32'(va[31:20]) << 2);
    exp_l2a = '0;
    if (!en) begin
      exp_flt = 2'd0; exp_pa = va; exp_aci = 4'd0; exp_lat = 1; exp_reads = 0;
      tag = "R9";
    end else begin
      dte = mem_word(exp_l1a);
      if (dte[1:0] != 2'b01) begin
        exp_flt = 2'd1; exp_pa = '0; exp_aci = 4'd0; exp_lat = 3 + lat; exp_reads = 1;
        tag = "R3";
      end else begin
        exp_l2a = {dte[31:10], 10'd0} + (32'(va[19:12]) << 2);
        pte = mem_word(exp_l2a);
        exp_reads = 2;
        exp_lat = 5 + 2 * lat;
        if (!pte[1]) begin
          exp_flt = 2'd2; exp_pa = '0; exp_aci = 4'd0; tag = "R5";
        end else begin
          exp_flt = 2'd0; exp_pa = {pte[31:12], va[11:0]}; exp_aci = pte[7:4]; tag = "R6";
        end
      end
    end
    exp_fva = (exp_flt != 2'd0) ? va : 32'd0;
    mem_lat = lat;
    nreads = 0;
    xlat_en = en;
    req_valid = 1'b1;
    req_va = va;
    @(negedge clk);
    cyc = 1;
    while (!rsp_valid_o && cyc < 64) begin
      req_valid = noise;
      req_va = ~va;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(rsp_valid_o && cyc == exp_lat, "R7 latency", 32'(cyc), 32'(exp_lat));
    chk(rsp_fault_o == exp_flt, tag, 32'(rsp_fault_o), 32'(exp_flt));
    chk(rsp_pa_o == exp_pa, en ? "R6 pa" : "R9 pa", rsp_pa_o, exp_pa);
    chk(rsp_aci_o == exp_aci, en ? "R6 aci" : "R9 aci", 32'(rsp_aci_o), 32'(exp_aci));
    chk(nreads == exp_reads, noise ? "R8 reads" : "R2 reads", 32'(nreads), 32'(exp_reads));
    if (exp_reads >= 1) chk(addr_log[0] == exp_l1a, "R2 dir addr", addr_log[0], exp_l1a);
    if (exp_reads >= 2) chk(addr_log[1] == exp_l2a, "R4 leaf addr", addr_log[1], exp_l2a);
    chk(fault_va_o == exp_fva, "R10 fault va", fault_va_o, exp_fva);
    @(negedge clk);
    chk(!rsp_valid_o && req_ready_o, "R7 pulse end", {30'd0, rsp_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !rsp_valid_o && !mem_req_o && fault_va_o == 0, "R1 reset",
        {29'd0, req_ready_o, rsp_valid_o, mem_req_o} | fault_va_o, 32'd4);

    // R2 R3 R4 R5 R6: every directory index
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] i1;
      logic [11:0] off;
      i1 = 12'(i);
      off = 12'(i * 499);
      do_req({i1, i1[7:0] ^ 8'h5A, off}, 1'b1, 0, 1'b0);
    end

    // R4 R5 R6 R7: every leaf slot under one valid directory entry, varied delay
    for (int j = 0; j < 256; j++) begin
      do_req({12'h0D5, 8'(j), 12'(j * 17)}, 1'b1, j % 3, 1'b0);
    end

    // R10: fault address held across idle cycles, then cleared by bypass
    do_req({12'h0D4, 8'h11, 12'h222}, 1'b1, 0, 1'b0);
    repeat (4) @(negedge clk);
    chk(fault_va_o == {12'h0D4, 8'h11, 12'h222}, "R10 held", fault_va_o,
        {12'h0D4, 8'h11, 12'h222});

    // R9: pass-through, including an address whose walk would succeed
    do_req(32'h0D50_1ABC, 1'b0, 0, 1'b0);
    do_req(32'hFFFF_FFFF, 1'b0, 2, 1'b0);
    do_req(32'h0000_0000, 1'b0, 0, 1'b1);

    // R8: request strobe held high while busy
    do_req({12'h0D5, 8'h04, 12'h321}, 1'b1, 1, 1'b1);
    do_req({12'h0D6, 8'h04, 12'h321}, 1'b1, 2, 1'b1);
    do_req({12'h001, 8'h00, 12'h000}, 1'b1, 0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule